// File: doc/BRIEF.md
# Extended Memory-Operation Execute Unit

This unit is an alternative execute stage for a 16-bit accumulator machine. The operand address has already been resolved by fetch and indirection logic. The unit accepts one instruction with a 3-bit opcode, that address and the current accumulator and program counter. It then runs a short timed microsequence over a shared data register and accumulator. Its arithmetic and logic unit can only add, XOR, transfer, complement and increment. From these few primitives it builds six memory operations: XOR into the accumulator, add into memory, subtract from the accumulator, exchange, skip-if-equal and branch-if-positive.

Execution begins in timing step T4, which is the cycle right after the instruction is accepted. The memory is read in that step. The longest path is subtraction, which ends in T8. In the final step of every sequence the unit raises `done`, which clears its sequence counter. From the following cycle it is idle again. The issue side is a valid/ready handshake. `iss_ready` is high only while the unit is idle, and an instruction offered while `iss_ready` is low is held off until the unit returns to idle. The memory port is plain control: a combinational read whose data is captured at the end of T4, and a write strobe lasting one cycle.

Top module: `xmri_unit`

## Requirements
- R1: `iss_ready` is high exactly when the unit is idle; an instruction is taken on a clock edge where `iss_valid` and `iss_ready` are both high, and `iss_ready` is low in the cycles that follow until the sequence has ended.
- R2: In the first execute cycle, opcodes 000 to 100 assert `mem_rd` with `mem_addr` equal to the accepted address; opcodes 101 to 111 never assert `mem_rd`.
- R3: Opcode 000 (XOR) leaves the accumulator equal to the old accumulator XOR the memory word, and `done` is high in the 2nd execute cycle.
- R4: Opcode 001 (add to memory) writes old accumulator plus memory word, modulo 2^16, to the operand address in the 3rd execute cycle. The accumulator ends unchanged, and `done` is high in that same cycle.
- R5: Opcode 010 (subtract) leaves the accumulator equal to the old accumulator minus the memory word, modulo 2^16. It does not write memory, and `done` is high in the 5th execute cycle.
- R6: Opcode 011 (exchange) writes the old accumulator to the operand address and loads the accumulator with the old memory word, both in the 2nd execute cycle. `done` is high in that cycle.
- R7: Opcode 100 (skip if equal) adds one to the program counter, modulo 2^12, when the accumulator equals the memory word. The accumulator ends unchanged, and `done` is high in the 3rd execute cycle.
- R8: Opcode 101 (branch if positive) loads the program counter with the operand address only when accumulator bit 15 is 0 and the accumulator is nonzero. `done` is high in the 1st execute cycle.
- R9: Opcodes 110 and 111 change neither the accumulator nor the program counter, access no memory, and raise `done` in the 1st execute cycle.
- R10: `mem_rd` and `mem_wr` are never high together, and `mem_wr` is high for exactly one cycle, and only for opcodes 001 and 011.
- R11: `done` is high for exactly one cycle per accepted instruction, and the unit is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Unit idle, instruction may be taken |
| iss_op | input | 3 | Operation code |
| iss_addr | input | 12 | Resolved operand address |
| iss_ac | input | 16 | Accumulator value at issue |
| iss_pc | input | 12 | Program counter value at issue |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data (combinational) |
| ac_q | output | 16 | Accumulator |
| pc_q | output | 12 | Program counter |
| done | output | 1 | Last execute step; sequence counter clears |

## Verification
Random opcodes, operands and addresses are mixed with directed cases, and the final accumulator, program counter, memory word and cycle count are each checked against a bench model. Subtraction is tried with a zero operand, with a result that borrows, and with equal operands; these separate a missing increment or complement step from a wrong swap order. Skip-if-equal is driven with equal and unequal pairs and with the program counter at its top value, which checks that it wraps to zero. Branch-if-positive is driven with zero, 0x8000, 0x7FFF and random accumulators, which shows whether the sign test and the zero test are both applied. Add-to-memory is run with operands that overflow, to check both the stored sum and the restored accumulator.

// File: rtl/xmri_pkg.sv
package xmri_pkg;

  typedef enum logic [2:0] {
    OP_XOR  = 3'd0,
    OP_ADM  = 3'd1,
    OP_SUB  = 3'd2,
    OP_XCH  = 3'd3,
    OP_SEQ  = 3'd4,
    OP_BPA  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    AC_HOLD    = 3'd0,
    AC_ADD     = 3'd1,
    AC_XOR     = 3'd2,
    AC_FROM_DR = 3'd3,
    AC_CMPL    = 3'd4,
    AC_INC     = 3'd5
  } ac_op_e;

  typedef enum logic [1:0] {
    DR_HOLD = 2'd0,
    DR_MEM  = 2'd1,
    DR_AC   = 2'd2
  } dr_op_e;

  typedef enum logic [1:0] {
    PC_HOLD   = 2'd0,
    PC_BR_POS = 2'd1,
    PC_SKIP_Z = 2'd2
  } pc_op_e;

  typedef struct packed {
    logic   rd;
    logic   wr;
    dr_op_e dr;
    ac_op_e ac;
    pc_op_e pc;
    logic   clr;
  } ctl_t;

  // first and last timing steps of execution
  localparam int T_FIRST = 4;
  localparam int T_LAST  = 8;

endpackage

// File: rtl/xmri_seq.sv
module xmri_seq
  import xmri_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr,
  output logic [TW-1:0] tstate,
  output logic          busy
);

  localparam logic [TW-1:0] T_LO = TW'(T_FIRST);
  localparam logic [TW-1:0] T_HI = TW'(T_LAST);

  assign busy = (tstate != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      tstate <= '0;
    else if (start)  tstate <= T_LO;
    else if (clr)    tstate <= '0;
    else if (busy)   tstate <= tstate + 1'b1;
  end

  AST_T_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tstate >= T_LO && tstate <= T_HI)); // R5

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R1

  AST_CLR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> busy); // R11

endmodule

// File: rtl/xmri_ctl.sv
module xmri_ctl
  import xmri_pkg::*;
#(
  parameter int TW = 4
) (
  input  op_e           op,
  input  logic [TW-1:0] tstate,
  output ctl_t          ctl
);

  localparam logic [TW-1:0] S4 = TW'(T_FIRST);
  localparam logic [TW-1:0] S5 = TW'(T_FIRST + 1);
  localparam logic [TW-1:0] S6 = TW'(T_FIRST + 2);
  localparam logic [TW-1:0] S7 = TW'(T_FIRST + 3);
  localparam logic [TW-1:0] S8 = TW'(T_FIRST + 4);

  always_comb begin
    ctl = '0;
    if (tstate == S4 && op <= OP_SEQ) begin
      ctl.rd = 1'b1;
      ctl.dr = DR_MEM;
    end
    unique case (op)
      OP_XOR: begin
        if (tstate == S5) begin
          ctl.ac  = AC_XOR;
          ctl.clr = 1'b1;
        end
      end
      OP_ADM: begin
        if (tstate == S5) begin
          ctl.dr = DR_AC;
          ctl.ac = AC_ADD;
        end else if (tstate == S6) begin
          ctl.wr  = 1'b1;
          ctl.ac  = AC_FROM_DR;
          ctl.clr = 1'b1;
        end
      end
      OP_SUB: begin
        if (tstate == S5) begin
          ctl.dr = DR_AC;
          ctl.ac = AC_FROM_DR;
        end else if (tstate == S6) begin
          ctl.ac = AC_CMPL;
        end else if (tstate == S7) begin
          ctl.ac = AC_INC;
        end else if (tstate == S8) begin
          ctl.ac  = AC_ADD;
          ctl.clr = 1'b1;
        end
      end
      OP_XCH: begin
        if (tstate == S5) begin
          ctl.wr  = 1'b1;
          ctl.ac  = AC_FROM_DR;
          ctl.clr = 1'b1;
        end
      end
      OP_SEQ: begin
        if (tstate == S5) begin
          ctl.dr = DR_AC;
          ctl.ac = AC_XOR;
        end else if (tstate == S6) begin
          ctl.pc  = PC_SKIP_Z;
          ctl.ac  = AC_FROM_DR;
          ctl.clr = 1'b1;
        end
      end
      OP_BPA: begin
        if (tstate == S4) begin
          ctl.pc  = PC_BR_POS;
          ctl.clr = 1'b1;
        end
      end
      default: begin
        if (tstate == S4) ctl.clr = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/xmri_alu.sv
module xmri_alu
  import xmri_pkg::*;
#(
  parameter int W = 16
) (
  input  ac_op_e       op,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] dr,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op)
      AC_ADD:     res = ac + dr;
      AC_XOR:     res = ac ^ dr;
      AC_FROM_DR: res = dr;
      AC_CMPL:    res = ~ac;
      AC_INC:     res = ac + ONE;
      default:    res = ac;
    endcase
  end

endmodule

// File: rtl/xmri_unit.sv
module xmri_unit
  import xmri_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [2:0]        iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_ac,
  input  logic [ADDR_W-1:0] iss_pc,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic              done
);

  localparam int TW = $clog2(T_LAST + 1);

  logic [TW-1:0]     tstate;
  logic              busy;
  logic              accept;
  ctl_t              ctl;
  op_e               op_q;
  logic [ADDR_W-1:0] ar_q;
  logic [DATA_W-1:0] dr_q;
  logic [DATA_W-1:0] alu_res;
  logic              ac_zero;
  logic              ac_pos;

  assign iss_ready = !busy;
  assign accept    = iss_valid && iss_ready;

  xmri_seq #(.TW(TW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .clr    (ctl.clr),
    .tstate (tstate),
    .busy   (busy)
  );

  xmri_ctl #(.TW(TW)) u_ctl (
    .op     (op_q),
    .tstate (tstate),
    .ctl    (ctl)
  );

  xmri_alu #(.W(DATA_W)) u_alu (
    .op  (ctl.ac),
    .ac  (ac_q),
    .dr  (dr_q),
    .res (alu_res)
  );

  assign ac_zero   = (ac_q == '0);
  assign ac_pos    = !ac_q[DATA_W-1] && !ac_zero;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign mem_addr  = ar_q;
  assign mem_wdata = ac_q;
  assign done      = ctl.clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= OP_XOR;
      ar_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
      pc_q <= '0;
    end else if (accept) begin
      op_q <= op_e'(iss_op);
      ar_q <= iss_addr;
      ac_q <= iss_ac;
      pc_q <= iss_pc;
    end else begin
      unique case (ctl.dr)
        DR_MEM:  dr_q <= mem_rdata;
        DR_AC:   dr_q <= ac_q;
        default: ;
      endcase
      if (ctl.ac != AC_HOLD) ac_q <= alu_res;
      unique case (ctl.pc)
        PC_BR_POS: if (ac_pos)  pc_q <= ar_q;
        PC_SKIP_Z: if (ac_zero) pc_q <= pc_q + 1'b1;
        default: ;
      endcase
    end
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_WR_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (op_q == OP_ADM || op_q == OP_XCH)); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> !iss_ready); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && iss_ready)); // R11

  AST_BPA_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_BPA && ac_q[DATA_W-1]) |=> $stable(pc_q)); // R8

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_RSV6 || op_q == OP_RSV7)) |=> ($stable(ac_q) && $stable(pc_q))); // R9

  AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(accept)); // R2

endmodule

// File: tb/xmri_unit_bench.sv
`timescale 1ns/1ps
module xmri_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [2:0]  iss_op = '0;
  logic [11:0] iss_addr = '0;
  logic [15:0] iss_ac = '0;
  logic [11:0] iss_pc = '0;
  logic        mem_rd, mem_wr, done;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] ac_q;
  logic [11:0] pc_q;

  logic [15:0] mem [0:255];
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  xmri_unit u_xmri_unit (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_addr(iss_addr), .iss_ac(iss_ac), .iss_pc(iss_pc),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ac_q(ac_q), .pc_q(pc_q), .done(done)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] op, input logic [15:0] m, input logic [15:0] a,
                       input logic [11:0] p, input logic [7:0] ad,
                       output logic [15:0] eac, output logic [11:0] epc,
                       output logic [15:0] emem, output int elat, output int ewr);
    eac = a; epc = p; emem = m; ewr = 0; elat = 1;
    case (op)
      3'd0: begin eac = a ^ m; elat = 2; end
      3'd1: begin emem = a + m; elat = 3; ewr = 1; end
      3'd2: begin eac = a - m; elat = 5; end
      3'd3: begin eac = m; emem = a; elat = 2; ewr = 1; end
      3'd4: begin if (a == m) epc = p + 12'd1; elat = 3; end
      3'd5: begin if (!a[15] && a != 16'd0) epc = {4'd0, ad}; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] ad,
                        input logic [15:0] a, input logic [11:0] p);
    logic [15:0] m, eac, emem;
    logic [11:0] epc;
    int elat, ewr, cyc, wrc;
    string tag;
    m = mem[ad];
    model(op, m, a, p, ad, eac, epc, emem, elat, ewr);
    case (op)
      3'd0: tag = "R3";
      3'd1: tag = "R4";
      3'd2: tag = "R5";
      3'd3: tag = "R6";
      3'd4: tag = "R7";
      3'd5: tag = "R8";
      default: tag = "R9";
    endcase
    @(negedge clk);
    chk("R1 ready when idle", iss_ready, 1);
    iss_valid = 1'b1; iss_op = op; iss_addr = {4'd0, ad}; iss_ac = a; iss_pc = p;
    @(negedge clk);
    iss_valid = 1'b0;
    chk("R1 busy after accept", iss_ready, 0);
    if (op <= 3'd4) begin
      chk("R2 read strobe in first step", mem_rd, 1);
      chk("R2 read address", mem_addr, {4'd0, ad});
    end else begin
      chk("R2 no read", mem_rd, 0);
    end
    cyc = 1; wrc = 0;
    forever begin
      if (mem_rd && mem_wr) chk("R10 read and write together", 1, 0);
      if (mem_wr) begin
        wrc++;
        chk({tag, " write data"}, mem_wdata, emem);
        chk({tag, " write address"}, mem_addr, {4'd0, ad});
      end
      if (done || cyc >= 16) break;
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    chk({tag, " latency"}, cyc, elat);
    chk({tag, " accumulator"}, ac_q, eac);
    chk({tag, " program counter"}, pc_q, epc);
    chk({tag, " memory word"}, mem[ad], emem);
    chk("R10 write count", wrc, ewr);
    chk("R11 done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0]  op;
    logic [7:0]  ad;
    logic [15:0] a;
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    chk("R1 reset ready", iss_ready, 1);
    chk("R11 reset done", done, 0);
    chk("R10 reset strobes", {mem_rd, mem_wr}, 0);
    chk("R10 reset accumulator", ac_q, 0);
    rst_n = 1'b1;

    // directed corners
    mem[8'h10] = 16'h0000; run_op(3'd2, 8'h10, 16'h1234, 12'h100);  // R5 zero operand
    mem[8'h11] = 16'h0001; run_op(3'd2, 8'h11, 16'h0000, 12'h100);  // R5 borrow
    mem[8'h12] = 16'h4321; run_op(3'd2, 8'h12, 16'h4321, 12'h100);  // R5 equal
    mem[8'h13] = 16'hFFFF; run_op(3'd1, 8'h13, 16'h0002, 12'h100);  // R4 overflow
    mem[8'h14] = 16'hBEEF; run_op(3'd4, 8'h14, 16'hBEEF, 12'hFFF);  // R7 wrap
    mem[8'h15] = 16'hBEEF; run_op(3'd4, 8'h15, 16'hBEEE, 12'h020);  // R7 unequal
    run_op(3'd5, 8'h40, 16'h0000, 12'h030);                          // R8 zero
    run_op(3'd5, 8'h41, 16'h8000, 12'h030);                          // R8 negative
    run_op(3'd5, 8'h42, 16'h7FFF, 12'h030);                          // R8 positive
    run_op(3'd6, 8'h43, 16'hA5A5, 12'h031);                          // R9
    run_op(3'd7, 8'h44, 16'h5A5A, 12'h032);                          // R9
    mem[8'h16] = 16'h00FF; run_op(3'd3, 8'h16, 16'hFF00, 12'h040);  // R6
    mem[8'h17] = 16'hF0F0; run_op(3'd0, 8'h17, 16'hFF00, 12'h040);  // R3

    // constrained random
    for (int n = 0; n < 400; n++) begin
      op = 3'($urandom_range(0, 7));
      ad = 8'($urandom);
      a  = 16'($urandom);
      if (op == 3'd4 && $urandom_range(0, 1) == 1) a = mem[ad];
      if (op == 3'd5 && $urandom_range(0, 3) == 0) a = 16'h0000;
      run_op(op, ad, a, 12'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule